// File: doc/BRIEF.md
# Boot Reset Release Sequencer

This block brings a two-processor system out of reset once power and clocks are known to be good. When its start input is raised, it holds both reset lines for a minimum time. It then lets the graphics processor out of reset and waits for that processor to report that its reset is done. Next it waits for the interconnect link to report the L0 state. It then lets the main processor out of reset and waits for a one-cycle handshake, which the main processor's software sends when it asks for the power-up cause.

Each of the three waits has its own timeout. A timeout ends the current attempt: both resets are driven again, and the sequence starts over from the minimum reset hold. The block allows five attempts in total. If the fifth attempt also times out, it stops in a permanent boot-error state. In that state it shows an 8-bit code that names the stage that failed last. If the handshake arrives, the block reports success and stays there. Lowering the start input at any time sends the block back to idle.

Top module: `boot_seq_top`

## Requirements
- R1: After reset, and while idle, both reset outputs are high (asserted), success_o and boot_err_o are low, err_code_o is 0x00 and attempt_o is 0.
- R2: After a launch, both resets stay asserted for HOLD_CYC cycles before the graphics reset is released. The main-processor reset is released only after the link has reported L0. The main-processor reset is never released while the graphics reset is asserted.
- R3: If reset-done is not seen within GPU_TMO cycles of entering the graphics wait, the attempt fails with stage code 0x08.
- R4: If L0 is not seen within LINK_TMO cycles of entering the link wait, the attempt fails with stage code 0x09. The count starts at zero on entry to the wait.
- R5: If the handshake is not seen within HS_TMO cycles of the main-processor reset release, the attempt fails with stage code 0x0A.
- R6: A failed attempt that is not the last one asserts both resets again and increments attempt_o. After HOLD_CYC cycles the graphics stage restarts.
- R7: When attempt MAX_TRIES (5) fails, boot_err_o goes high and stays high while start_i stays high. At the same time attempt_o holds 5, both resets stay asserted and err_code_o holds the code of the failing stage.
- R8: When the handshake arrives, success_o goes high and stays high while start_i stays high. attempt_o is frozen and both resets stay released, whatever the other inputs do.
- R9: An acknowledge that arrives in the last cycle of a wait window takes priority over the timeout, and the sequence advances.
- R10: Raising start_i launches the sequence only from idle. Holding it high in the success or error state does not relaunch. Lowering it returns the block to idle within one cycle and clears the code, the flags and the attempt count.
- R11: An acknowledge for a stage that is not being waited on is ignored. While the block waits for reset-done, for example, L0 and the handshake do not advance it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Level: power and clocks good, run the sequence |
| gpu_done_i | input | 1 | Graphics processor reports that its reset is done |
| link_l0_i | input | 1 | Interconnect link is in the L0 state |
| handshake_i | input | 1 | Software handshake pulse from the main processor |
| gpu_rst_o | output | 1 | Graphics reset, 1 = asserted |
| cpu_rst_o | output | 1 | Main-processor reset, 1 = asserted |
| success_o | output | 1 | Sequence completed |
| boot_err_o | output | 1 | Permanent boot error |
| err_code_o | output | 8 | Stage code: 0x08 graphics, 0x09 link, 0x0A handshake, 0x00 none |
| attempt_o | output | $clog2(MAX_TRIES+1) | Number of the current attempt, starting at 1 |

## Verification
Every output comes straight from the state register or from the error-code register, so each result appears one clock edge after the input that causes it. A launch therefore releases the graphics reset after HOLD_CYC+1 edges. An unanswered graphics wait ends after GPU_TMO further edges. The bench drives inputs and samples outputs on falling edges, and it counts edges from the launch to the exact edge where each change is due. It checks the cycle before that edge and the cycle after it. One attempt lasts HOLD_CYC+GPU_TMO, HOLD_CYC+1+LINK_TMO or HOLD_CYC+2+HS_TMO cycles, depending on which stage fails. The permanent error is checked at five of these periods plus one, with a check of the cycle just before it.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_WGPU  = 3'd2,
        ST_WLINK = 3'd3,
        ST_WHS   = 3'd4,
        ST_DONE  = 3'd5,
        ST_FAIL  = 3'd6
    } seq_state_e;

    localparam logic [7:0] CODE_NONE = 8'h00;
    localparam logic [7:0] CODE_GPU  = 8'h08;
    localparam logic [7:0] CODE_LINK = 8'h09;
    localparam logic [7:0] CODE_HS   = 8'h0A;

    typedef struct packed {
        logic gpu_rst;
        logic cpu_rst;
    } rst_ctl_t;

    // Code reported when the wait in a given state times out
    function automatic logic [7:0] stage_code(seq_state_e s);
        case (s)
            ST_WGPU:  return CODE_GPU;
            ST_WLINK: return CODE_LINK;
            ST_WHS:   return CODE_HS;
            default:  return CODE_NONE;
        endcase
    endfunction

    // Reset line levels for each state (1 = held in reset)
    function automatic rst_ctl_t reset_ctl(seq_state_e s);
        rst_ctl_t r;
        case (s)
            ST_WGPU, ST_WLINK: begin r.gpu_rst = 1'b0; r.cpu_rst = 1'b1; end
            ST_WHS, ST_DONE:   begin r.gpu_rst = 1'b0; r.cpu_rst = 1'b0; end
            default:           begin r.gpu_rst = 1'b1; r.cpu_rst = 1'b1; end
        endcase
        return r;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/boot_seq_timer.sv
module boot_seq_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [TW-1:0] cnt
);
    // Cycles spent in the current state; restarts on every state change
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != {TW{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/boot_seq_retry.sv
module boot_seq_retry #(
    parameter int unsigned MAX_TRIES = 5,
    localparam int unsigned CW = $clog2(MAX_TRIES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          first,
    input  logic          bump,
    output logic [CW-1:0] count,
    output logic          last_try
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (first) begin
            count <= CW'(1);
        end else if (bump && count < CW'(MAX_TRIES)) begin
            count <= count + 1'b1;
        end
    end

    assign last_try = (count == CW'(MAX_TRIES));

    // R6: the attempt number never runs past the budget
    assert_attempt_range_R6: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(MAX_TRIES));

    // R6: every retry moves the attempt number up by exactly one
    assert_attempt_step_R6: assert property (@(posedge clk) disable iff (rst)
        (bump && !clr && !first) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import boot_seq_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 64,
    parameter int unsigned GPU_TMO  = 1000,
    parameter int unsigned LINK_TMO = 1000,
    parameter int unsigned HS_TMO   = 2000,
    parameter int unsigned TW       = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          gpu_done_i,
    input  logic          link_l0_i,
    input  logic          handshake_i,
    input  logic [TW-1:0] tcnt,
    input  logic          last_try,
    output seq_state_e    state_q,
    output logic          tmr_clr,
    output logic          try_clr,
    output logic          try_first,
    output logic          try_bump,
    output logic [7:0]    code_q
);
    localparam logic [TW-1:0] LIM_HOLD = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] LIM_GPU  = TW'(GPU_TMO - 1);
    localparam logic [TW-1:0] LIM_LINK = TW'(LINK_TMO - 1);
    localparam logic [TW-1:0] LIM_HS   = TW'(HS_TMO - 1);

    seq_state_e state_d;
    logic [7:0] code_d;
    logic       expire;
    logic       stage_fail;

    always_comb begin
        case (state_q)
            ST_HOLD:  expire = (tcnt == LIM_HOLD);
            ST_WGPU:  expire = (tcnt == LIM_GPU);
            ST_WLINK: expire = (tcnt == LIM_LINK);
            ST_WHS:   expire = (tcnt == LIM_HS);
            default:  expire = 1'b0;
        endcase
    end

    always_comb begin
        state_d    = state_q;
        code_d     = code_q;
        try_clr    = 1'b0;
        try_first  = 1'b0;
        try_bump   = 1'b0;
        stage_fail = 1'b0;
        if (!start_i) begin
            state_d = ST_IDLE;
            code_d  = CODE_NONE;
            try_clr = 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    state_d   = ST_HOLD;
                    try_first = 1'b1;
                end
                ST_HOLD:  if (expire) state_d = ST_WGPU;
                ST_WGPU: begin
                    if (gpu_done_i)  state_d = ST_WLINK;
                    else if (expire) stage_fail = 1'b1;
                end
                ST_WLINK: begin
                    if (link_l0_i)   state_d = ST_WHS;
                    else if (expire) stage_fail = 1'b1;
                end
                ST_WHS: begin
                    if (handshake_i) state_d = ST_DONE;
                    else if (expire) stage_fail = 1'b1;
                end
                default: state_d = state_q;
            endcase
            if (stage_fail) begin
                if (last_try) begin
                    state_d = ST_FAIL;
                    code_d  = stage_code(state_q);
                end else begin
                    state_d  = ST_HOLD;
                    try_bump = 1'b1;
                end
            end
        end
    end

    assign tmr_clr = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= CODE_NONE;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // R3: the graphics wait never outlives its window
    assert_gpu_window_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WGPU) |-> tcnt < TW'(GPU_TMO));

    // R4: the link wait never outlives its window
    assert_link_window_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WLINK) |-> tcnt < TW'(LINK_TMO));

    // R5: the handshake wait never outlives its window
    assert_hs_window_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WHS) |-> tcnt < TW'(HS_TMO));

    // R10: a dropped start always lands in idle on the next edge
    assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> state_q == ST_IDLE);

    // R7: the error state and its code hold while start stays high
    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FAIL && start_i) |=> (state_q == ST_FAIL && $stable(code_q)));
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
    import boot_seq_pkg::*;
#(
    parameter int unsigned HOLD_CYC  = 64,
    parameter int unsigned GPU_TMO   = 1000,
    parameter int unsigned LINK_TMO  = 1000,
    parameter int unsigned HS_TMO    = 2000,
    parameter int unsigned MAX_TRIES = 5
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start_i,
    input  logic                             gpu_done_i,
    input  logic                             link_l0_i,
    input  logic                             handshake_i,
    output logic                             gpu_rst_o,
    output logic                             cpu_rst_o,
    output logic                             success_o,
    output logic                             boot_err_o,
    output logic [7:0]                       err_code_o,
    output logic [$clog2(MAX_TRIES+1)-1:0]   attempt_o
);
    localparam int unsigned MAXLIM = max2(max2(HOLD_CYC, GPU_TMO), max2(LINK_TMO, HS_TMO));
    localparam int unsigned TW     = $clog2(MAXLIM + 1);

    seq_state_e    state_q;
    logic [TW-1:0] tcnt;
    logic          tmr_clr;
    logic          try_clr;
    logic          try_first;
    logic          try_bump;
    logic          last_try;
    rst_ctl_t      rctl;

    boot_seq_timer #(.TW(TW)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (tmr_clr),
        .cnt (tcnt)
    );

    boot_seq_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
        .clk      (clk),
        .rst      (rst),
        .clr      (try_clr),
        .first    (try_first),
        .bump     (try_bump),
        .count    (attempt_o),
        .last_try (last_try)
    );

    boot_seq_fsm #(
        .HOLD_CYC (HOLD_CYC),
        .GPU_TMO  (GPU_TMO),
        .LINK_TMO (LINK_TMO),
        .HS_TMO   (HS_TMO),
        .TW       (TW)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .gpu_done_i  (gpu_done_i),
        .link_l0_i   (link_l0_i),
        .handshake_i (handshake_i),
        .tcnt        (tcnt),
        .last_try    (last_try),
        .state_q     (state_q),
        .tmr_clr     (tmr_clr),
        .try_clr     (try_clr),
        .try_first   (try_first),
        .try_bump    (try_bump),
        .code_q      (err_code_o)
    );

    assign rctl       = reset_ctl(state_q);
    assign gpu_rst_o  = rctl.gpu_rst;
    assign cpu_rst_o  = rctl.cpu_rst;
    assign success_o  = (state_q == ST_DONE);
    assign boot_err_o = (state_q == ST_FAIL);

    // R2: the main processor is never out of reset while graphics is held
    assert_release_order_R2: assert property (@(posedge clk) disable iff (rst)
        !cpu_rst_o |-> !gpu_rst_o);

    // R8: success holds and freezes the attempt number
    assert_success_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (success_o && start_i) |=> (success_o && $stable(attempt_o)));

    // R7: a permanent error carries a stage code and keeps both resets asserted
    assert_err_code_R7: assert property (@(posedge clk) disable iff (rst)
        boot_err_o |-> ((err_code_o == CODE_GPU || err_code_o == CODE_LINK ||
                         err_code_o == CODE_HS) && gpu_rst_o && cpu_rst_o));

    // R7: the error only starts once the final attempt has been used
    assert_err_on_last_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(boot_err_o) |-> attempt_o == ($clog2(MAX_TRIES+1))'(MAX_TRIES));
endmodule

// File: tb/boot_seq_top_bench.sv
module boot_seq_top_bench;
    localparam int unsigned H   = 8;
    localparam int unsigned TG  = 20;
    localparam int unsigned TL  = 30;
    localparam int unsigned TS  = 40;
    localparam int unsigned MT  = 5;
    localparam int unsigned PG  = H + TG;
    localparam int unsigned PL  = H + 1 + TL;
    localparam int unsigned PS  = H + 2 + TS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       gpu_done_i = 1'b0;
    logic       link_l0_i = 1'b0;
    logic       handshake_i = 1'b0;
    logic       gpu_rst_o;
    logic       cpu_rst_o;
    logic       success_o;
    logic       boot_err_o;
    logic [7:0] err_code_o;
    logic [2:0] attempt_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    boot_seq_top #(
        .HOLD_CYC (H), .GPU_TMO (TG), .LINK_TMO (TL), .HS_TMO (TS), .MAX_TRIES (MT)
    ) u_boot_seq_top (
        .clk (clk), .rst (rst), .start_i (start_i), .gpu_done_i (gpu_done_i),
        .link_l0_i (link_l0_i), .handshake_i (handshake_i),
        .gpu_rst_o (gpu_rst_o), .cpu_rst_o (cpu_rst_o), .success_o (success_o),
        .boot_err_o (boot_err_o), .err_code_o (err_code_o), .attempt_o (attempt_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        start_i = 0; gpu_done_i = 0; link_l0_i = 0; handshake_i = 0;
        tick(2);
    endtask

    task automatic t_reset();
        chk("R1 gpu reset held", gpu_rst_o, 1);
        chk("R1 cpu reset held", cpu_rst_o, 1);
        chk("R1 success low", success_o, 0);
        chk("R1 error low", boot_err_o, 0);
        chk("R1 code zero", err_code_o, 0);
        chk("R1 attempt zero", attempt_o, 0);
    endtask

    task automatic t_success();
        start_i = 1;
        tick(1);
        chk("R2 attempt one", attempt_o, 1);
        tick(H - 1);
        chk("R2 gpu held through hold", gpu_rst_o, 1);
        tick(1);
        chk("R2 gpu released", gpu_rst_o, 0);
        chk("R2 cpu still held", cpu_rst_o, 1);
        tick(5);
        gpu_done_i = 1;
        tick(1);
        chk("R2 cpu held until L0", cpu_rst_o, 1);
        link_l0_i = 1;
        tick(1);
        chk("R2 cpu released after L0", cpu_rst_o, 0);
        handshake_i = 1;
        tick(1);
        handshake_i = 0;
        chk("R8 success", success_o, 1);
        gpu_done_i = 0; link_l0_i = 0;
        tick(10);
        chk("R8 success sticky", success_o, 1);
        chk("R8 attempt frozen", attempt_o, 1);
        chk("R10 no relaunch from success", gpu_rst_o, 0);
        start_i = 0;
        tick(1);
        chk("R10 drop clears success", success_o, 0);
        chk("R10 drop asserts cpu reset", cpu_rst_o, 1);
        chk("R10 drop asserts gpu reset", gpu_rst_o, 1);
        chk("R10 drop clears attempt", attempt_o, 0);
        go_idle();
    endtask

    task automatic t_gpu_fail();
        link_l0_i = 1; handshake_i = 1;
        start_i = 1;
        tick(PG);
        chk("R11 still in gpu wait", gpu_rst_o, 0);
        chk("R11 cpu held despite L0 and handshake", cpu_rst_o, 1);
        tick(1);
        chk("R6 gpu reset reasserted", gpu_rst_o, 1);
        chk("R6 cpu reset reasserted", cpu_rst_o, 1);
        chk("R6 attempt two", attempt_o, 2);
        tick(H - 1);
        chk("R6 hold repeated", gpu_rst_o, 1);
        tick(1);
        chk("R6 gpu stage restarted", gpu_rst_o, 0);
        tick(MT * PG - (PG + 1 + H));
        chk("R7 no error before last timeout", boot_err_o, 0);
        tick(1);
        chk("R7 error set", boot_err_o, 1);
        chk("R3 code 08", err_code_o, 8'h08);
        chk("R7 attempt five", attempt_o, MT);
        chk("R7 gpu reset held", gpu_rst_o, 1);
        tick(20);
        chk("R7 error sticky", boot_err_o, 1);
        chk("R10 no relaunch from error", attempt_o, MT);
        start_i = 0;
        tick(1);
        chk("R10 drop clears error", boot_err_o, 0);
        chk("R10 drop clears code", err_code_o, 0);
        go_idle();
    endtask

    task automatic t_link_fail();
        gpu_done_i = 1;
        start_i = 1;
        tick(PL);
        chk("R4 still in link wait", gpu_rst_o, 0);
        tick(1);
        chk("R4 attempt ended", gpu_rst_o, 1);
        chk("R4 attempt two", attempt_o, 2);
        tick(MT * PL - PL - 1);
        chk("R4 no error before last timeout", boot_err_o, 0);
        tick(1);
        chk("R4 error set", boot_err_o, 1);
        chk("R4 code 09", err_code_o, 8'h09);
        go_idle();
    endtask

    task automatic t_hs_fail();
        gpu_done_i = 1; link_l0_i = 1;
        start_i = 1;
        tick(PS);
        chk("R5 cpu still released", cpu_rst_o, 0);
        tick(1);
        chk("R5 cpu reset reasserted", cpu_rst_o, 1);
        chk("R5 attempt two", attempt_o, 2);
        tick(MT * PS - PS - 1);
        chk("R5 no error before last timeout", boot_err_o, 0);
        tick(1);
        chk("R5 error set", boot_err_o, 1);
        chk("R5 code 0A", err_code_o, 8'h0A);
        go_idle();
    endtask

    task automatic t_last_cycle_ack();
        start_i = 1;
        tick(PG);
        gpu_done_i = 1;
        tick(1);
        chk("R9 gpu still released", gpu_rst_o, 0);
        chk("R9 attempt unchanged", attempt_o, 1);
        tick(1);
        chk("R9 now in link wait", cpu_rst_o, 1);
        chk("R9 no retry", attempt_o, 1);
        go_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        t_reset();
        t_success();
        t_gpu_fail();
        t_link_fail();
        t_hs_fail();
        t_last_cycle_ack();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule